// File: doc/BRIEF.md
# Decimate-by-two symmetric FIR with one shared multiply-accumulate unit

This block filters a stream of signed samples and halves its rate. It is meant for the compensation or channel-select stage of a digital down-converter. Every sample that arrives with its strobe is written into a circular history buffer. On every second accepted sample, a sequencer computes the full convolution for that instant. Because the taps are a linear-phase (symmetric) set, the sequencer adds each mirrored pair of history samples first. A single multiplier then scales the sum by the shared coefficient, so one output costs ceil(N/2) multiply cycles instead of N.

The result is accumulated at full precision. It is then rounded to nearest, saturated to the output width and presented for one clock with its own strobe. The coefficient set comes in on a flat vector that holds only the unique half of the taps.

Samples keep arriving while a result is being computed, and the block stores them without upsetting the computation in flight. The system clock must provide at least ceil(N/2) cycles between two consecutive result requests. The tap count is a parameter: odd counts such as 21 and 63 and even counts are all accepted, with a minimum of 3.

Top module: `dec2_fir_mac`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) drives out_valid low, clears the pairing phase and zeroes the whole sample history, so the first results after reset treat all earlier samples as zero.
- R2: A result is requested by the 2nd, 4th, 6th, ... accepted sample counted since reset. The 1st, 3rd, ... samples only fill the history.
- R3: For a request made by sample x[n], out_data is the value of sum over k = 0..NTAPS-1 of h[k]*x[n-k], with h[k] = h[NTAPS-1-k]. The unique half of the taps sits in coef_flat, with h[k] in bits [k*CW +: CW] as a signed value. For an odd NTAPS the middle tap is applied once.
- R4: out_valid is high for exactly one cycle, NH+1 rising edges after the edge that accepted the requesting sample, where NH = ceil(NTAPS/2). It is low in every other cycle.
- R5: The full-precision sum is reduced by dropping SHIFT LSBs with round to nearest. Exact halves round toward plus infinity, so +0.5 LSB gives 1 and -0.5 LSB gives 0.
- R6: A rounded value above 2^(OW-1)-1 or below -2^(OW-1) is clamped to that limit.
- R7: A sample accepted while a result is being computed is stored and used by later results, and the result in flight is unchanged.
- R8: A request accepted on the final multiply cycle of the previous result starts a new computation at once, so requests NH cycles apart each produce a result.
- R9: A request that arrives earlier than the final multiply cycle of the running computation produces no result. Its sample is still stored and the pairing phase still advances.
- R10: While in_valid is low, in_data is ignored: neither the history nor the pairing phase changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking a new input sample |
| in_data | input | DW | Signed input sample |
| coef_flat | input | NH*CW | Unique half of the symmetric taps, tap k at bits [k*CW +: CW] |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | OW | Signed rounded and saturated result |

## Verification
A wrong write pointer or pairing phase shows at the ports within one output period, as a shifted window of history in out_data or as a result strobe on the wrong sample. A sequencer that loses its place shows as a strobe missing or off by a cycle from the NH+1 latency. The bench therefore compares out_valid and out_data with a behavioural model on every clock. The mixes of bursts, back-to-back requests, early requests and idle gaps are chosen so that overwrite and restart faults reach the output within a few results.

// File: rtl/dec2_pkg.sv
package dec2_pkg;

    // Sequencer activity
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    // Per-cycle control word travelling alongside the MAC operands
    typedef struct packed {
        logic valid;   // a tap pair is issued this cycle
        logic first;   // first pair of a convolution: accumulator restarts
        logic last;    // final pair: result is produced after it
        logic mid;     // centre tap of an odd-length filter: no partner sample
    } mac_ctl_t;

    // Number of distinct coefficients (and MAC cycles) for a symmetric filter
    function automatic int half_taps(input int ntaps);
        return (ntaps + 1) / 2;
    endfunction

    // History must hold NTAPS samples plus every sample that can land during one run
    function automatic int ring_addr_bits(input int ntaps);
        return $clog2(ntaps + half_taps(ntaps));
    endfunction

endpackage

// File: rtl/dec2_sample_ring.sv
module dec2_sample_ring #(
    parameter int DW  = 16,
    parameter int RAW = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_data,
    output logic [RAW-1:0] wr_ptr,
    input  logic [RAW-1:0] rd_addr_a,
    input  logic [RAW-1:0] rd_addr_b,
    output logic [DW-1:0]  rd_data_a,
    output logic [DW-1:0]  rd_data_b
);
    localparam int DEPTH = 1 << RAW;

    logic [DW-1:0] mem [DEPTH];

    // Every strobed sample is stored, regardless of sequencer activity
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wr_ptr <= '0;
        end else if (wr_en) begin
            mem[wr_ptr] <= wr_data;
            wr_ptr      <= wr_ptr + 1'b1;
        end
    end

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];

    // R10: pointer advances exactly once per accepted sample and holds otherwise
    assert_wr_step_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (wr_ptr == RAW'($past(wr_ptr) + 1'b1)));
    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(wr_ptr));

endmodule

// File: rtl/dec2_mac_seq.sv
module dec2_mac_seq
    import dec2_pkg::*;
#(
    parameter int NTAPS = 21,
    parameter int NH    = 11,
    parameter int RAW   = 5,
    parameter int KW    = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_req,
    input  logic [RAW-1:0] wr_ptr,
    output logic [RAW-1:0] rd_addr_a,
    output logic [RAW-1:0] rd_addr_b,
    output logic [KW-1:0]  tap_idx,
    output mac_ctl_t       ctl
);
    localparam logic [KW-1:0]  K_LAST = KW'(NH - 1);
    localparam logic [RAW-1:0] SPAN   = RAW'(NTAPS - 1);
    localparam bit             ODD    = (NTAPS % 2) == 1;

    seq_state_t     state;
    logic [KW-1:0]  k;
    logic [RAW-1:0] base;   // ring slot of the newest sample of this convolution
    logic           accept;

    // A request is taken when idle, or on the last pair of the running convolution
    assign accept = start_req && ((state == SEQ_IDLE) || (k == K_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            k     <= '0;
            base  <= '0;
        end else if (accept) begin
            state <= SEQ_RUN;
            k     <= '0;
            base  <= wr_ptr;   // slot being written by the requesting sample
        end else if (state == SEQ_RUN) begin
            if (k == K_LAST) begin
                state <= SEQ_IDLE;
                k     <= '0;
            end else begin
                k <= k + 1'b1;
            end
        end
    end

    // Mirrored pair: newest-k and oldest+k of the window
    assign rd_addr_a = base - RAW'(k);
    assign rd_addr_b = base - SPAN + RAW'(k);
    assign tap_idx   = k;

    always_comb begin
        ctl.valid = (state == SEQ_RUN);
        ctl.first = (k == '0);
        ctl.last  = (k == K_LAST);
        ctl.mid   = ODD && (k == K_LAST);
    end

    // R8: an accepted request always restarts at the first pair
    assert_accept_load_R8: assert property (@(posedge clk) disable iff (rst)
        accept |=> (state == SEQ_RUN) && (k == '0));
    // R9: an early request does not disturb the running walk
    assert_busy_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (start_req && (state == SEQ_RUN) && (k != K_LAST)) |=> (k == KW'($past(k) + 1'b1)));

endmodule

// File: rtl/dec2_mac_datapath.sv
module dec2_mac_datapath
    import dec2_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int OW    = 16,
    parameter int NH    = 11,
    parameter int KW    = 4,
    parameter int SHIFT = 15,
    parameter bit ODD   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  mac_ctl_t         ctl,
    input  logic [KW-1:0]    tap_idx,
    input  logic [DW-1:0]    xa,
    input  logic [DW-1:0]    xb,
    input  logic [NH*CW-1:0] coef_flat,
    output logic             out_valid,
    output logic [OW-1:0]    out_data
);
    localparam int SW   = DW + 1;
    localparam int PW   = SW + CW;
    localparam int ACCW = PW + $clog2(NH);
    localparam logic signed [ACCW:0] RND_ONE = (ACCW+1)'(1) <<< (SHIFT - 1);
    localparam logic signed [ACCW:0] OMAX    = (ACCW+1)'((64'sd1 <<< (OW - 1)) - 64'sd1);
    localparam logic signed [ACCW:0] OMIN    = ~OMAX;

    logic signed [SW-1:0]   xsum;
    logic signed [CW-1:0]   coef;
    logic signed [PW-1:0]   prod, prod_q;
    mac_ctl_t               pctl;
    logic signed [ACCW-1:0] acc, acc_next;
    logic signed [ACCW:0]   rnd, shifted;
    logic [OW-1:0]          sat_val;

    // Pre-adder: the centre tap of an odd filter has no partner
    generate
        if (ODD) begin : g_odd
            always_comb xsum = ctl.mid ? SW'($signed(xa))
                                       : SW'($signed(xa)) + SW'($signed(xb));
        end else begin : g_even
            always_comb xsum = SW'($signed(xa)) + SW'($signed(xb));
        end
    endgenerate

    assign coef = coef_flat[int'(tap_idx)*CW +: CW];
    assign prod = PW'(xsum) * PW'(coef);

    // Stage 1: product register
    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            pctl   <= '0;
        end else begin
            prod_q <= prod;
            pctl   <= ctl;
        end
    end

    // Stage 2: accumulate, round, saturate
    always_comb begin
        acc_next = pctl.first ? ACCW'(prod_q) : acc + ACCW'(prod_q);
        rnd      = (ACCW+1)'(acc_next) + RND_ONE;
        shifted  = rnd >>> SHIFT;
        if (shifted > OMAX)      sat_val = OMAX[OW-1:0];
        else if (shifted < OMIN) sat_val = OMIN[OW-1:0];
        else                     sat_val = shifted[OW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= pctl.valid && pctl.last;
            if (pctl.valid) acc <= acc_next;
            if (pctl.valid && pctl.last) out_data <= sat_val;
        end
    end

    // R4: the final pair is followed by exactly one result strobe
    assert_last_to_out_R4: assert property (@(posedge clk) disable iff (rst)
        (pctl.valid && pctl.last) |=> out_valid);
    assert_out_single_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

endmodule

// File: rtl/dec2_fir_mac.sv
module dec2_fir_mac
    import dec2_pkg::*;
#(
    parameter  int NTAPS = 21,
    parameter  int DW    = 16,
    parameter  int CW    = 16,
    parameter  int OW    = 16,
    parameter  int SHIFT = 15,
    localparam int NH    = half_taps(NTAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    input  logic [NH*CW-1:0] coef_flat,
    output logic             out_valid,
    output logic [OW-1:0]    out_data
);
    localparam int RAW = ring_addr_bits(NTAPS);
    localparam int KW  = $clog2(NH);
    localparam bit ODD = (NTAPS % 2) == 1;

    logic           phase;       // high when the next sample completes a pair
    logic           start_req;
    logic [RAW-1:0] wr_ptr, rd_addr_a, rd_addr_b;
    logic [DW-1:0]  xa, xb;
    logic [KW-1:0]  tap_idx;
    mac_ctl_t       ctl;

    always_ff @(posedge clk) begin
        if (rst)           phase <= 1'b0;
        else if (in_valid) phase <= ~phase;
    end

    assign start_req = in_valid && phase;

    dec2_sample_ring #(.DW(DW), .RAW(RAW)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (in_valid),
        .wr_data   (in_data),
        .wr_ptr    (wr_ptr),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_a (xa),
        .rd_data_b (xb)
    );

    dec2_mac_seq #(.NTAPS(NTAPS), .NH(NH), .RAW(RAW), .KW(KW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .wr_ptr    (wr_ptr),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .tap_idx   (tap_idx),
        .ctl       (ctl)
    );

    dec2_mac_datapath #(
        .DW(DW), .CW(CW), .OW(OW), .NH(NH), .KW(KW), .SHIFT(SHIFT), .ODD(ODD)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .tap_idx   (tap_idx),
        .xa        (xa),
        .xb        (xb),
        .coef_flat (coef_flat),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R2: each accepted sample flips the pairing phase
    assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (phase != $past(phase)));
    // R10: no strobe, no phase change
    assert_phase_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(phase));

endmodule

// File: tb/sim_dec2_fir_mac.sv
module sim_dec2_fir_mac;
    localparam int NTAPS = 21;
    localparam int DW    = 16;
    localparam int CW    = 16;
    localparam int OW    = 16;
    localparam int SHIFT = 15;
    localparam int NH    = (NTAPS + 1) / 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic [NH*CW-1:0]     coef_flat;
    logic                 out_valid;
    logic signed [OW-1:0] out_data;

    always #4 clk = ~clk;   // 125 MHz

    dec2_fir_mac #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .OW(OW), .SHIFT(SHIFT)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .coef_flat(coef_flat), .out_valid(out_valid), .out_data(out_data)
    );

    int     n_checks = 0;
    int     n_fail   = 0;
    int     cyc      = 0;
    string  tag      = "R1";
    bit     done     = 1'b0;
    int     h_half [NH];
    longint hist [$];
    bit     ph = 1'b0;
    int     remain = 0;
    longint exp_at [int];
    int     exp_pulses = 0;
    int     seen_pulses = 0;

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    function automatic longint tap(int k);
        return longint'(h_half[(k < NH) ? k : NTAPS - 1 - k]);
    endfunction

    // Behavioural convolution over the model history (newest first)
    function automatic longint ref_out();
        longint s = 0;
        longint r;
        longint lim = (64'sd1 <<< (OW - 1)) - 1;
        for (int k = 0; k < NTAPS; k++)
            if (k < hist.size()) s += tap(k) * hist[k];
        r = (s + (64'sd1 <<< (SHIFT - 1))) >>> SHIFT;
        if (r > lim) r = lim;
        if (r < -lim - 1) r = -lim - 1;
        return r;
    endfunction

    // Reference model, updated on each rising edge
    always @(posedge clk) begin
        bit accept;
        cyc++;
        if (rst) begin
            hist.delete();
            ph = 1'b0;
            remain = 0;
            exp_at.delete();
        end else begin
            accept = 1'b0;
            if (in_valid) begin
                hist.push_front(longint'(in_data));
                if (hist.size() > NTAPS) void'(hist.pop_back());
                if (ph && remain <= 1) accept = 1'b1;
                ph = !ph;
            end
            if (accept) begin
                exp_at[cyc + NH + 1] = ref_out();
                exp_pulses++;
                remain = NH;
            end else if (remain > 0) begin
                remain--;
            end
        end
    end

    // Output comparison every cycle, away from the rising edge
    always @(negedge clk) begin
        if (rst) begin
            check(out_valid == 1'b0, "R1", "out_valid during reset", longint'(out_valid), 0);
        end else begin
            if (out_valid) seen_pulses++;
            if (exp_at.exists(cyc)) begin
                check(out_valid == 1'b1, tag, "out_valid at expected cycle", longint'(out_valid), 1);
                check(longint'(out_data) == exp_at[cyc], tag, "out_data", longint'(out_data), exp_at[cyc]);
                exp_at.delete(cyc);
            end else begin
                check(out_valid == 1'b0, tag, "out_valid outside result cycle", longint'(out_valid), 0);
            end
        end
    end

    task automatic step(bit v, int d);
        @(negedge clk);
        in_valid = v;
        in_data  = DW'(d);
    endtask

    task automatic paced(int d);   // one sample every 8 cycles
        step(1'b1, d);
        repeat (7) step(1'b0, 0);
    endtask

    function automatic int rnd16();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    task automatic begin_scn(string t);
        repeat (NH + 4) step(1'b0, 0);
        tag = t;
        exp_pulses  = 0;
        seen_pulses = 0;
    endtask

    task automatic end_scn();
        repeat (NH + 4) step(1'b0, 0);
        check(seen_pulses == exp_pulses, tag, "result count", seen_pulses, exp_pulses);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        for (int k = 0; k < NH; k++) begin
            if (k == 0)           h_half[k] = 1;
            else if (k == 1)      h_half[k] = -3;
            else if (k == NH - 1) h_half[k] = 20000;
            else                  h_half[k] = ((k * 1237) % 6000) - 1500;
            coef_flat[k*CW +: CW] = CW'(h_half[k]);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: zero history after reset, results from a single pair
        begin_scn("R1");
        step(1'b1, 12000); step(1'b1, -7000);
        end_scn();

        // R2/R3: impulse then random data, paced
        begin_scn("R3");
        paced(30000);
        for (int i = 0; i < NTAPS + 3; i++) paced(0);
        for (int i = 0; i < 30; i++) paced(rnd16());
        end_scn();

        begin_scn("R2");
        for (int i = 0; i < 9; i++) paced(rnd16());
        end_scn();

        // R4: result latency checked on every cycle for alternating spacing
        begin_scn("R4");
        for (int i = 0; i < 10; i++) begin
            step(1'b1, rnd16()); step(1'b1, rnd16());
            repeat (NH + (i % 3)) step(1'b0, 0);
        end
        end_scn();

        // R5: exact half-LSB ties on the one-valued tap
        begin_scn("R5");
        for (int i = 0; i < NTAPS + 1; i++) paced(0);
        paced(0); paced(16384);
        for (int i = 0; i < NTAPS + 1; i++) paced(0);
        paced(0); paced(-16384);
        for (int i = 0; i < 4; i++) paced(0);
        end_scn();

        // R6: full-scale inputs saturate both ways
        begin_scn("R6");
        for (int i = 0; i < NTAPS + 5; i++) paced(32767);
        for (int i = 0; i < NTAPS + 5; i++) paced(-32768);
        end_scn();

        // R7: a sample lands while a result is computing
        begin_scn("R7");
        for (int i = 0; i < 8; i++) begin
            step(1'b1, rnd16()); step(1'b1, rnd16());
            step(1'b0, 0); step(1'b1, rnd16());
            repeat (NH - 3) step(1'b0, 0);
            step(1'b1, rnd16());
            repeat (3) step(1'b0, 0);
        end
        end_scn();

        // R8: requests exactly NH cycles apart
        begin_scn("R8");
        for (int i = 0; i < 8; i++) begin
            step(1'b1, rnd16()); step(1'b1, rnd16());
            repeat (NH - 2) step(1'b0, 0);
        end
        end_scn();

        // R9: requests one cycle too early are dropped
        begin_scn("R9");
        for (int i = 0; i < 8; i++) begin
            step(1'b1, rnd16()); step(1'b1, rnd16());
            repeat (NH - 3) step(1'b0, 0);
        end
        end_scn();
        check(seen_pulses == 4, "R9", "results from eight early-paced pairs", seen_pulses, 4);

        // R10: in_data toggles with in_valid low
        begin_scn("R10");
        for (int i = 0; i < 12; i++) begin
            step(1'b1, rnd16());
            repeat (5) step(1'b0, rnd16());
        end
        end_scn();

        // R1: reset mid-stream clears the history
        begin_scn("R1");
        for (int i = 0; i < NTAPS; i++) paced(25000);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(1'b1, 9000); step(1'b1, -3000);
        end_scn();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule